// File: doc/BRIEF.md
# Serial CODEC Sample Transmitter

This block sends one audio sample per frame to a serial CODEC over a single data line. The bit clock and frame sync are supplied from outside, and the block runs entirely on the rising edge of the bit clock. It samples the frame sync on that edge and compares it with its registered previous value to find each new frame. At that edge it takes one word from an upstream holding register or FIFO through a valid/ready handshake and captures it in a shift register. It then shifts the 8-bit or 16-bit sample out, most significant or least significant bit first. After the last sample bit it drives zeros until the next frame begins.

Two settings fix when the first bit goes out, and both are latched at the frame start. A timing select chooses between the bit-clock cycle of the detected sync edge and one cycle later. The length of the frame sync pulse has no effect. If no word is offered at a frame start, the block sends an all-zero sample and raises a one-cycle underrun pulse. An unsupported sample-size code keeps the line quiet.

Top module: `codecSampleTx`

## Requirements
- R1: While reset is asserted and on the first edge after it, `txData`, `underrun` and `sampleReady` are 0.
- R2: `sampleReady` is 1 only in a cycle where `frameSync` is 1, its value sampled at the previous edge was 0, and `sizeSel` is valid. When `sampleValid` is also 1 in that cycle, the word is consumed.
- R3: `sizeSel` = 2'b01 sends 8 bits taken from `sampleData[7:0]`. `sizeSel` = 2'b10 sends all 16 bits of `sampleData`.
- R4: With `earlyStart` = 1, the first sample bit appears on `txData` at the clock edge where the sync rise is detected. With `earlyStart` = 0, it appears one edge later.
- R5: `lsbFirst` = 0 sends the highest sample bit first (bit 7 or bit 15). `lsbFirst` = 1 sends bit 0 first.
- R6: After the last sample bit, `txData` stays 0 until the next detected sync rise.
- R7: The number of cycles `frameSync` stays high has no effect on the output; only its rising edge starts a frame.
- R8: If `sampleValid` is 0 when `sampleReady` is 1, the frame carries all zeros. `underrun` is then 1 for exactly the one cycle after that edge.
- R9: Changes to `sampleData`, `sizeSel`, `earlyStart` and `lsbFirst` after the frame-start edge do not alter the frame in progress.
- R10: When `sizeSel` is 2'b00 or 2'b11 at a sync rise, no word is taken, `underrun` stays 0, and `txData` is 0 for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all logic uses its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| frameSync | input | 1 | Frame sync from the CODEC side |
| sizeSel | input | 2 | Sample size code: 01 = 8 bits, 10 = 16 bits, others idle |
| earlyStart | input | 1 | 1 = first bit at the sync edge, 0 = one cycle later |
| lsbFirst | input | 1 | 1 = least significant bit first |
| sampleData | input | 16 | Sample word from the transmit store |
| sampleValid | input | 1 | A sample word is offered |
| sampleReady | output | 1 | Word is consumed this cycle (frame start) |
| txData | output | 1 | Serial data to the CODEC |
| underrun | output | 1 | One-cycle pulse: frame started with no word offered |

## Verification
Most wrong internal states show up within one frame. A bad bit counter shows as a frame whose sample is one bit short or long, or whose zero fill starts early, visible within sixteen bit clocks of the sync edge. A wrongly latched direction or size appears as reversed or truncated bits in that same frame. Stale edge-detect state shows as a missing or repeated `sampleReady` pulse at the very edge it concerns. Changing the settings in the middle of a frame shows whether the frame-start capture holds.

// File: rtl/codec_tx_pkg.sv
package codec_tx_pkg;

  typedef enum logic [1:0] {
    SIZE_OFF   = 2'b00,
    SIZE_SHORT = 2'b01,
    SIZE_WIDE  = 2'b10,
    SIZE_RSVD  = 2'b11
  } sizeCode_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;      // frame start: capture a new word
    logic fill;      // a word was offered (else zeros)
    logic emitNow;   // drive first bit in the load cycle
    logic shift;     // emit next bit from the shift register
    logic lsb;       // direction in effect
    logic wide;      // long sample in effect
  } txStrobe_t;

endpackage

// File: rtl/codecTxCtrl.sv
module codecTxCtrl
  import codec_tx_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SHORT_W  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameSync,
  input  logic [1:0] sizeSel,
  input  logic       earlyStart,
  input  logic       lsbFirst,
  input  logic       sampleValid,
  output logic       sampleReady,
  output logic       underrun,
  output txStrobe_t  stb
);

  localparam int CW = $clog2(SAMPLE_W + 1);
  localparam logic [CW-1:0] LEN_WIDE  = CW'(SAMPLE_W);
  localparam logic [CW-1:0] LEN_SHORT = CW'(SHORT_W);

  logic          syncPrev;
  logic          riseSeen;
  logic          sizeOk;
  logic          sizeWide;
  logic          frameGo;
  logic [CW-1:0] bitsLeft;
  logic [CW-1:0] startCount;
  logic          lsbQ;
  logic          wideQ;

  assign riseSeen = frameSync & ~syncPrev;
  assign sizeWide = (sizeSel == SIZE_WIDE);
  assign sizeOk   = (sizeSel == SIZE_SHORT) || sizeWide;
  assign frameGo  = riseSeen & sizeOk;
  assign sampleReady = frameGo;

  assign startCount = (sizeWide ? LEN_WIDE : LEN_SHORT) - CW'(earlyStart);

  // syncPrev resets high so a sync already high out of reset is no edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncPrev <= 1'b1;
      bitsLeft <= '0;
      lsbQ     <= 1'b0;
      wideQ    <= 1'b0;
      underrun <= 1'b0;
    end else begin
      syncPrev <= frameSync;
      underrun <= frameGo & ~sampleValid;
      if (frameGo) begin
        bitsLeft <= startCount;
        lsbQ     <= lsbFirst;
        wideQ    <= sizeWide;
      end else if (riseSeen) begin
        bitsLeft <= '0;
      end else if (bitsLeft != '0) begin
        bitsLeft <= bitsLeft - 1'b1;
      end
    end
  end

  always_comb begin
    stb.load    = frameGo;
    stb.fill    = sampleValid;
    stb.emitNow = earlyStart;
    stb.shift   = ~riseSeen && (bitsLeft != '0);
    stb.lsb     = frameGo ? lsbFirst : lsbQ;
    stb.wide    = frameGo ? sizeWide : wideQ;
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    bitsLeft <= LEN_WIDE);

  // R10: an unsupported size never hands out a ready
  assert_idle_no_ready_R10: assert property (@(posedge clk) disable iff (!rstN)
    sampleReady |-> (sizeSel == SIZE_SHORT || sizeSel == SIZE_WIDE));

  assert_ready_on_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    sampleReady |-> (frameSync && !$past(frameSync)));

  // R7: a held-high sync gives no second frame start
  assert_no_repeat_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && $past(frameSync)) |-> !sampleReady);

endmodule

// File: rtl/codecTxPath.sv
module codecTxPath
  import codec_tx_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SHORT_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  txStrobe_t           stb,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic                txData
);

  localparam int PAD_W = SAMPLE_W - SHORT_W;
  localparam logic [SAMPLE_W-1:0] LOW_MASK = {SAMPLE_W{1'b1}} >> PAD_W;

  logic [SAMPLE_W-1:0] shReg;
  logic [SAMPLE_W-1:0] lowPart;
  logic [SAMPLE_W-1:0] aligned;
  logic [SAMPLE_W-1:0] newWord;
  logic [SAMPLE_W-1:0] curWord;
  logic [SAMPLE_W-1:0] nextWord;
  logic                headBit;

  // short samples sit at the end the shifter drains first
  assign lowPart = sampleData & LOW_MASK;
  always_comb begin
    if (stb.wide)     aligned = sampleData;
    else if (stb.lsb) aligned = lowPart;
    else              aligned = lowPart << PAD_W;
  end
  assign newWord = stb.fill ? aligned : '0;

  assign curWord  = stb.load ? newWord : shReg;
  assign headBit  = stb.lsb ? curWord[0] : curWord[SAMPLE_W-1];
  assign nextWord = stb.lsb ? (curWord >> 1) : (curWord << 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      txData <= 1'b0;
    end else if (stb.load) begin
      if (stb.emitNow) begin
        txData <= headBit;
        shReg  <= nextWord;
      end else begin
        txData <= 1'b0;
        shReg  <= newWord;
      end
    end else if (stb.shift) begin
      txData <= headBit;
      shReg  <= nextWord;
    end else begin
      txData <= 1'b0;
    end
  end

  assert_fill_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.load && !stb.shift) |=> !txData);

  assert_late_start_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && !stb.emitNow) |=> !txData);

endmodule

// File: rtl/codecSampleTx.sv
module codecSampleTx
  import codec_tx_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SHORT_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameSync,
  input  logic [1:0]          sizeSel,
  input  logic                earlyStart,
  input  logic                lsbFirst,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                sampleValid,
  output logic                sampleReady,
  output logic                txData,
  output logic                underrun
);

  txStrobe_t stb;

  codecTxCtrl #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .frameSync   (frameSync),
    .sizeSel     (sizeSel),
    .earlyStart  (earlyStart),
    .lsbFirst    (lsbFirst),
    .sampleValid (sampleValid),
    .sampleReady (sampleReady),
    .underrun    (underrun),
    .stb         (stb)
  );

  codecTxPath #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) i_path (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .sampleData (sampleData),
    .txData     (txData)
  );

  assert_underrun_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> !txData);

  assert_underrun_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> !underrun);

endmodule

// File: tb/test_codecSampleTx.sv
`timescale 1ns/1ps
module test_codecSampleTx;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameSync = 1'b0;
  logic [1:0]  sizeSel = 2'b00;
  logic        earlyStart = 1'b0;
  logic        lsbFirst = 1'b0;
  logic [15:0] sampleData = '0;
  logic        sampleValid = 1'b0;
  logic        sampleReady;
  logic        txData;
  logic        underrun;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  codecSampleTx i_codecSampleTx (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .sizeSel(sizeSel),
    .earlyStart(earlyStart), .lsbFirst(lsbFirst), .sampleData(sampleData),
    .sampleValid(sampleValid), .sampleReady(sampleReady), .txData(txData),
    .underrun(underrun)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sampleLen(input logic [1:0] sz);
    return (sz == 2'b10) ? 16 : ((sz == 2'b01) ? 8 : 0);
  endfunction

  // expected line value k edges after the frame-start edge
  function automatic int expBit(input logic [15:0] d, input logic [1:0] sz,
                                input bit lsb, input bit early, input bit valid, input int k);
    int len = sampleLen(sz);
    int j = early ? k : k - 1;
    if (len == 0 || !valid) return 0;
    if (j < 0 || j >= len) return 0;
    return lsb ? int'(d[j]) : int'(d[len-1-j]);
  endfunction

  task automatic runFrame(input logic [1:0] sz, input bit early, input bit lsb,
                          input logic [15:0] d, input bit valid, input int frameLen,
                          input int syncLen);
    bit ok = (sz == 2'b01 || sz == 2'b10);
    @(negedge clk);
    frameSync = 1'b1; sizeSel = sz; earlyStart = early; lsbFirst = lsb;
    sampleData = d; sampleValid = valid;
    #0.5;
    check("R2", "ready at rise", int'(sampleReady), int'(ok));
    for (int k = 0; k < frameLen; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(ok ? (k < 17 ? "R4/R5/R3" : "R6") : "R10", "txData",
            int'(txData), expBit(d, sz, lsb, early, valid, k));
      if (k == 0) check("R8", "underrun pulse", int'(underrun), int'(ok && !valid));
      if (k == 1) check("R8", "underrun one cycle", int'(underrun), 0);
      if (frameSync) check("R7", "no ready on held sync", int'(sampleReady), 0);
      if (k == 0) begin
        // R9: disturb every setting mid-frame
        sampleValid = 1'b0;
        sampleData  = 16'($urandom);
        sizeSel     = 2'($urandom);
        earlyStart  = 1'($urandom);
        lsbFirst    = 1'($urandom);
      end
      if (k + 1 == syncLen) frameSync = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_C0DE));
    // R1: reset state, sync high in reset gives no frame start
    frameSync = 1'b1; sizeSel = 2'b01; sampleValid = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "txData in reset", int'(txData), 0);
    check("R1", "underrun in reset", int'(underrun), 0);
    check("R1", "ready in reset", int'(sampleReady), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "ready after reset", int'(sampleReady), 0);
    check("R1", "txData after reset", int'(txData), 0);
    frameSync = 1'b0;
    repeat (3) @(negedge clk);

    // directed corners
    runFrame(2'b01, 1'b1, 1'b0, 16'h00A5, 1'b1, 20, 1);   // R3 R4 R5 msb early 8-bit
    runFrame(2'b01, 1'b0, 1'b1, 16'hFF3C, 1'b1, 20, 19);  // R7 wide sync, lsb late
    runFrame(2'b10, 1'b1, 1'b1, 16'h8001, 1'b1, 18, 2);   // R3 16-bit lsb early
    runFrame(2'b10, 1'b0, 1'b0, 16'hC3A6, 1'b1, 18, 17);  // 16-bit msb late, full use
    runFrame(2'b10, 1'b0, 1'b0, 16'hFFFF, 1'b0, 20, 5);   // R8 underrun
    runFrame(2'b01, 1'b1, 1'b0, 16'hFFFF, 1'b0, 20, 5);   // R8 underrun early
    runFrame(2'b00, 1'b1, 1'b0, 16'hFFFF, 1'b1, 20, 3);   // R10 idle
    runFrame(2'b11, 1'b0, 1'b1, 16'hFFFF, 1'b1, 20, 3);   // R10 reserved
    runFrame(2'b10, 1'b1, 1'b0, 16'hFFFF, 1'b1, 24, 1);   // R6 zero fill after ones

    // constrained random frames
    for (int n = 0; n < 80; n++) begin
      int fl = 18 + int'($urandom_range(0, 12));
      int sl = 1 + int'($urandom_range(0, fl - 2));
      logic [1:0] sz = ($urandom_range(0, 9) == 0) ? 2'b11 : 2'($urandom_range(1, 2));
      bit vv = ($urandom_range(0, 5) != 0);
      runFrame(sz, 1'($urandom), 1'($urandom), 16'($urandom), vv, fl, sl);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule